// File: doc/BRIEF.md
# Minimum Integration Interval Scheduler

This block paces the frame requests sent to a linear image sensor's readout engine. A free-running microsecond time base is kept inside the block and driven by a one-cycle tick strobe. Its value is offered at `nowUs` so that the readout logic can stamp when each integration period and each pixel transfer began. When the readout engine signals that a frame has been fully transferred, the scheduler measures how long the sensor has been integrating. If that is still short of the programmed minimum, it waits out the shortfall in microsecond ticks. If the minimum has already been met, it waits exactly one tick. In both cases it then emits a single-cycle frame request.

The same frame-done event feeds a set of readout statistics: a 64-bit running total of transfer durations, a frame count, and the shortest and longest durations seen. A sequential restoring divider then produces the mean transfer time from the total and the count, with a valid flag. A clear input returns all statistics to their initial values. All time differences use modulo-2^32 arithmetic, so a wrap of the time base does not disturb any measurement.

Top module: `intSched`

## Requirements
- R1: After reset, `frameReq` is 0, `statTotal` is 0, `statCount` is 0, `statMin` is all ones, `statMax` is 0, `avgValid` is 0, `nowUs` is 0, and the stored minimum integration time is 0.
- R2: `nowUs` advances by one on every clock cycle in which `usTick` is 1, wrapping modulo 2^32, and holds its value otherwise.
- R3: On a cycle with `frameDone` high, the elapsed time is E = `nowUs` − `intStartUs` (mod 2^32). If E is less than the stored minimum M, `frameReq` is high for one cycle right after the (M−E)-th `usTick` cycle that follows the frame-done cycle.
- R4: If E ≥ M, including M = 0, `frameReq` is high for one cycle right after the first `usTick` cycle that follows the frame-done cycle.
- R5: A cycle with `minIntWr` high stores `minIntVal` as M. A frame-done in the same cycle still uses the previously stored M. Every later frame-done uses the new value.
- R6: On frame-done without a clear, the duration D = `nowUs` − `xferStartUs` (mod 2^32) is added to `statTotal`, zero-extended, and `statCount` increments by one. Both are visible on the next cycle.
- R7: On frame-done without a clear, `statMin` becomes min(`statMin`, D) and `statMax` becomes max(`statMax`, D).
- R8: A cycle with `statClr` high restores the R1 values of `statTotal`, `statCount`, `statMin`, `statMax` and `avgValid`. This takes priority over a frame-done in the same cycle, whose request is still scheduled.
- R9: After each statistics update, `avgValid` falls. Within 70 cycles it rises again, with `avgUs` equal to the integer quotient `statTotal` / `statCount`.
- R10: A frame-done that arrives while a request is pending discards the pending wait and schedules a new one from its own evaluation. `frameReq` is never high for two cycles in a row.
- R11: Wrap-around of time stamps is handled. An `intStartUs` or `xferStartUs` numerically larger than `nowUs` yields the modulo-2^32 difference for E and D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| usTick | input | 1 | One-cycle strobe per elapsed microsecond |
| frameDone | input | 1 | One-cycle strobe: pixel transfer of a frame finished |
| xferStartUs | input | 32 | Time stamp at which the finished transfer began |
| intStartUs | input | 32 | Time stamp at which the current integration period began |
| minIntWr | input | 1 | Write strobe for the minimum integration time |
| minIntVal | input | 32 | Minimum integration time in microseconds |
| statClr | input | 1 | Clears the statistics |
| nowUs | output | 32 | Microsecond time base |
| frameReq | output | 1 | One-cycle request to start the next frame |
| statTotal | output | 64 | Sum of transfer durations |
| statCount | output | 32 | Number of frames accumulated |
| statMin | output | 32 | Shortest transfer duration |
| statMax | output | 32 | Longest transfer duration |
| avgUs | output | 32 | Mean transfer duration |
| avgValid | output | 1 | `avgUs` matches the current statistics |

## Verification
The assertions assume that `usTick` and `frameDone` are single-cycle strobes. They also assume the frame count never wraps, so the ordering of minimum and maximum and the bound of the mean by the maximum hold whenever the count is nonzero. The bench drives every strobe for exactly one cycle from tasks, issues far fewer than 2^32 frames, and stamps start times relative to its own model of the time base. It sweeps minimum settings and elapsed times from 0 to 6 in both directions of the comparison. The first frame is evaluated with the time base near zero and stamps placed just before the wrap point.

// File: rtl/intSchedPkg.sv
`timescale 1ns/1ps
package intSchedPkg;

  typedef enum logic {
    SCH_IDLE = 1'b0,
    SCH_WAIT = 1'b1
  } schedStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic loadWait;   // evaluate and load the countdown
    logic decWait;    // consume one microsecond of the countdown
    logic updStats;   // fold a transfer duration into the statistics
    logic clrStats;   // restore initial statistics
    logic startDiv;   // launch a mean computation
  } schedStrobeT;

endpackage

// File: rtl/intSchedCtrl.sv
`timescale 1ns/1ps
module intSchedCtrl
  import intSchedPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        usTick,
  input  logic        frameDone,
  input  logic        statClr,
  input  logic        waitIsOne,
  output schedStrobeT strobe,
  output logic        frameReq
);

  schedStateT state;
  logic       divGoQ;
  logic       fireNow;

  assign fireNow = (state == SCH_WAIT) && usTick && waitIsOne && !frameDone;

  always_comb begin
    strobe          = '0;
    strobe.loadWait = frameDone;
    strobe.decWait  = (state == SCH_WAIT) && usTick && !frameDone;
    strobe.updStats = frameDone && !statClr;
    strobe.clrStats = statClr;
    strobe.startDiv = divGoQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= SCH_IDLE;
      frameReq <= 1'b0;
      divGoQ   <= 1'b0;
    end else begin
      divGoQ   <= frameDone && !statClr;
      frameReq <= fireNow;
      if (frameDone) begin
        state <= SCH_WAIT;
      end else if (fireNow) begin
        state <= SCH_IDLE;
      end
    end
  end

  // R10: request is a single-cycle pulse
  p_req_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    frameReq |=> !frameReq);

  // R10: a request only follows a pending wait
  p_req_after_wait_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!frameReq) ##1 frameReq |-> $past(state == SCH_WAIT));

  // R4: frame-done always leaves a pending wait
  p_done_arms_r4: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> (state == SCH_WAIT) && !frameReq);

endmodule

// File: rtl/intSchedDp.sv
`timescale 1ns/1ps
module intSchedDp
  import intSchedPkg::*;
#(
  parameter int TIME_W = 32,
  parameter int TOT_W  = 64,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  schedStrobeT       strobe,
  input  logic              usTick,
  input  logic              minIntWr,
  input  logic [TIME_W-1:0] minIntVal,
  input  logic [TIME_W-1:0] xferStartUs,
  input  logic [TIME_W-1:0] intStartUs,
  output logic [TIME_W-1:0] nowUs,
  output logic              waitIsOne,
  output logic [TOT_W-1:0]  statTotal,
  output logic [CNT_W-1:0]  statCount,
  output logic [TIME_W-1:0] statMin,
  output logic [TIME_W-1:0] statMax
);

  localparam logic [TIME_W-1:0] ONE_US   = TIME_W'(1);
  localparam logic [TIME_W-1:0] MIN_INIT = '1;

  logic [TIME_W-1:0] minIntReg;
  logic [TIME_W-1:0] waitCnt;
  logic [TIME_W-1:0] elapsedUs;
  logic [TIME_W-1:0] delayUs;
  logic [TIME_W-1:0] durUs;

  // modulo-2^32 differences (R11)
  assign elapsedUs = nowUs - intStartUs;
  assign durUs     = nowUs - xferStartUs;
  assign delayUs   = (elapsedUs < minIntReg) ? (minIntReg - elapsedUs) : ONE_US;
  assign waitIsOne = (waitCnt == ONE_US);

  // time base (R2)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      nowUs <= '0;
    end else if (usTick) begin
      nowUs <= nowUs + ONE_US;
    end
  end

  // minimum integration setting (R5)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      minIntReg <= '0;
    end else if (minIntWr) begin
      minIntReg <= minIntVal;
    end
  end

  // countdown (R3, R4, R10)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitCnt <= '0;
    end else if (strobe.loadWait) begin
      waitCnt <= delayUs;
    end else if (strobe.decWait && (waitCnt != '0)) begin
      waitCnt <= waitCnt - ONE_US;
    end
  end

  // statistics (R6, R7, R8)
  always_ff @(posedge clk) begin
    if (!rstN || strobe.clrStats) begin
      statTotal <= '0;
      statCount <= '0;
      statMin   <= MIN_INIT;
      statMax   <= '0;
    end else if (strobe.updStats) begin
      statTotal <= statTotal + TOT_W'(durUs);
      statCount <= statCount + CNT_W'(1);
      if (durUs < statMin) statMin <= durUs;
      if (durUs > statMax) statMax <= durUs;
    end
  end

  // R2: time base steps only on a tick
  p_tick_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    usTick |=> nowUs == $past(nowUs) + ONE_US);

  p_tick_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !usTick |=> $stable(nowUs));

  // R3: a loaded wait is never zero
  p_wait_loaded_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadWait |=> waitCnt != '0);

  // R6: one count per accepted frame
  p_count_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.updStats && !strobe.clrStats |=> statCount == $past(statCount) + CNT_W'(1));

  // R7: shortest never exceeds longest once a frame was seen
  p_min_le_max_r7: assert property (@(posedge clk) disable iff (!rstN)
    (statCount != '0) |-> statMin <= statMax);

  // R8: clear restores initial values
  p_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrStats |=> (statTotal == '0) && (statCount == '0)
                        && (statMin == MIN_INIT) && (statMax == '0));

endmodule

// File: rtl/intSchedDiv.sv
`timescale 1ns/1ps
module intSchedDiv #(
  parameter int DVD_W = 64,
  parameter int DVS_W = 32,
  parameter int Q_W   = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             abort,
  input  logic [DVD_W-1:0] dividend,
  input  logic [DVS_W-1:0] divisor,
  output logic [Q_W-1:0]   quot,
  output logic             valid
);

  localparam int STEP_W = $clog2(DVD_W + 1);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(DVD_W - 1);

  logic             busy;
  logic [STEP_W-1:0] step;
  logic [DVD_W-1:0] work;       // dividend shifts out, quotient shifts in
  logic [DVS_W:0]   rem;
  logic [DVS_W-1:0] dvsReg;
  logic [DVS_W:0]   remShift;
  logic [DVS_W:0]   remNext;
  logic             fits;

  always_comb begin
    remShift = {rem[DVS_W-1:0], work[DVD_W-1]};
    fits     = remShift >= {1'b0, dvsReg};
    remNext  = fits ? (remShift - {1'b0, dvsReg}) : remShift;
  end

  always_ff @(posedge clk) begin
    if (!rstN || abort) begin
      busy   <= 1'b0;
      valid  <= 1'b0;
      step   <= '0;
      work   <= '0;
      rem    <= '0;
      dvsReg <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      valid  <= 1'b0;
      step   <= '0;
      work   <= dividend;
      rem    <= '0;
      dvsReg <= divisor;
    end else if (busy) begin
      rem  <= remNext;
      work <= {work[DVD_W-2:0], fits};
      step <= step + STEP_W'(1);
      if (step == LAST_STEP) begin
        busy  <= 1'b0;
        valid <= 1'b1;
      end
    end
  end

  assign quot = work[Q_W-1:0];

  // R9: the result is never flagged while iterating
  p_valid_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    valid |-> !busy);

  // R9: a start always withdraws the old result
  p_start_drops_r9: assert property (@(posedge clk) disable iff (!rstN)
    start && !abort |=> !valid && busy);

endmodule

// File: rtl/intSched.sv
`timescale 1ns/1ps
module intSched
  import intSchedPkg::*;
#(
  parameter int TIME_W = 32,
  parameter int TOT_W  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              usTick,
  input  logic              frameDone,
  input  logic [TIME_W-1:0] xferStartUs,
  input  logic [TIME_W-1:0] intStartUs,
  input  logic              minIntWr,
  input  logic [TIME_W-1:0] minIntVal,
  input  logic              statClr,
  output logic [TIME_W-1:0] nowUs,
  output logic              frameReq,
  output logic [TOT_W-1:0]  statTotal,
  output logic [TIME_W-1:0] statCount,
  output logic [TIME_W-1:0] statMin,
  output logic [TIME_W-1:0] statMax,
  output logic [TIME_W-1:0] avgUs,
  output logic              avgValid
);

  localparam int CNT_W = TIME_W;

  schedStrobeT strobe;
  logic        waitIsOne;

  intSchedCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .usTick    (usTick),
    .frameDone (frameDone),
    .statClr   (statClr),
    .waitIsOne (waitIsOne),
    .strobe    (strobe),
    .frameReq  (frameReq)
  );

  intSchedDp #(
    .TIME_W (TIME_W),
    .TOT_W  (TOT_W),
    .CNT_W  (CNT_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .usTick      (usTick),
    .minIntWr    (minIntWr),
    .minIntVal   (minIntVal),
    .xferStartUs (xferStartUs),
    .intStartUs  (intStartUs),
    .nowUs       (nowUs),
    .waitIsOne   (waitIsOne),
    .statTotal   (statTotal),
    .statCount   (statCount),
    .statMin     (statMin),
    .statMax     (statMax)
  );

  intSchedDiv #(
    .DVD_W (TOT_W),
    .DVS_W (CNT_W),
    .Q_W   (TIME_W)
  ) u_div (
    .clk      (clk),
    .rstN     (rstN),
    .start    (strobe.startDiv),
    .abort    (strobe.clrStats),
    .dividend (statTotal),
    .divisor  (statCount),
    .quot     (avgUs),
    .valid    (avgValid)
  );

  // R9: a mean never exceeds the longest duration
  p_avg_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    avgValid && (statCount != '0) |-> avgUs <= statMax);

  // R8: clear withdraws the mean
  p_clear_avg_r8: assert property (@(posedge clk) disable iff (!rstN)
    statClr |=> !avgValid);

endmodule

// File: tb/test_intSched.sv
`timescale 1ns/1ps
module test_intSched;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        usTick = 1'b0;
  logic        frameDone = 1'b0;
  logic [31:0] xferStartUs = '0;
  logic [31:0] intStartUs = '0;
  logic        minIntWr = 1'b0;
  logic [31:0] minIntVal = '0;
  logic        statClr = 1'b0;
  logic [31:0] nowUs;
  logic        frameReq;
  logic [63:0] statTotal;
  logic [31:0] statCount;
  logic [31:0] statMin;
  logic [31:0] statMax;
  logic [31:0] avgUs;
  logic        avgValid;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [31:0] nowModel = '0;
  logic [31:0] minModel = '0;
  logic [63:0] expTotal = '0;
  logic [31:0] expCount = '0;
  logic [31:0] expMin = '1;
  logic [31:0] expMax = '0;

  always #2.5 clk = ~clk;

  intSched i_intSched (
    .clk (clk), .rstN (rstN), .usTick (usTick), .frameDone (frameDone),
    .xferStartUs (xferStartUs), .intStartUs (intStartUs),
    .minIntWr (minIntWr), .minIntVal (minIntVal), .statClr (statClr),
    .nowUs (nowUs), .frameReq (frameReq), .statTotal (statTotal),
    .statCount (statCount), .statMin (statMin), .statMax (statMax),
    .avgUs (avgUs), .avgValid (avgValid)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tickOnce();
    @(negedge clk) usTick = 1'b1;
    @(negedge clk) usTick = 1'b0;
    nowModel = nowModel + 32'd1;
  endtask

  task automatic setMin(input logic [31:0] v);
    @(negedge clk) begin minIntWr = 1'b1; minIntVal = v; end
    @(negedge clk) minIntWr = 1'b0;
    minModel = v;
  endtask

  task automatic checkStats(input string tag);
    check(statTotal == expTotal, {tag, " total"}, statTotal, expTotal);
    check(statCount == expCount, {tag, " count"}, statCount, expCount);
    check(statMin == expMin, {tag, " min"}, statMin, expMin);
    check(statMax == expMax, {tag, " max"}, statMax, expMax);
  endtask

  // frame-done with given elapsed and duration; optional same-cycle write / clear
  task automatic frameEvent(input logic [31:0] elapsed, input logic [31:0] dur,
                            input bit wr, input logic [31:0] wrVal, input bit clr,
                            output logic [31:0] expDelay);
    expDelay = (elapsed < minModel) ? (minModel - elapsed) : 32'd1;
    @(negedge clk) begin
      frameDone   = 1'b1;
      intStartUs  = nowModel - elapsed;
      xferStartUs = nowModel - dur;
      minIntWr    = wr;
      minIntVal   = wrVal;
      statClr     = clr;
    end
    @(negedge clk) begin
      frameDone = 1'b0; minIntWr = 1'b0; statClr = 1'b0;
    end
    if (wr) minModel = wrVal;
    if (clr) begin
      expTotal = '0; expCount = '0; expMin = '1; expMax = '0;
    end else begin
      expTotal = expTotal + {32'd0, dur};
      expCount = expCount + 32'd1;
      if (dur < expMin) expMin = dur;
      if (dur > expMax) expMax = dur;
    end
  endtask

  // count ticks until the request; expect it after exactly expDelay ticks
  task automatic runSchedule(input logic [31:0] expDelay, input string tag);
    int got = -1;
    for (int k = 1; k <= int'(expDelay) + 2; k++) begin
      tickOnce();
      if (frameReq) begin
        got = k;
        break;
      end
    end
    check(got == int'(expDelay), {tag, " request delay"}, got, expDelay);
    @(negedge clk);
    check(frameReq == 1'b0, {tag, " request pulse width R10"}, frameReq, 0);
  endtask

  task automatic checkAvg(input string tag);
    int n = 0;
    while (!avgValid && n < 300) begin
      @(negedge clk);
      n++;
    end
    check(avgValid == 1'b1, {tag, " avgValid R9"}, avgValid, 1);
    check(avgUs == 32'(expTotal / {32'd0, expCount}), {tag, " mean R9"},
          avgUs, expTotal / {32'd0, expCount});
  endtask

  initial begin
    #500000;
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(frameReq == 1'b0, "R1 frameReq", frameReq, 0);
    check(nowUs == 32'd0, "R1 nowUs", nowUs, 0);
    check(avgValid == 1'b0, "R1 avgValid", avgValid, 0);
    checkStats("R1");

    // R11 wrap: time base at 0, stamps just below 2^32
    setMin(32'd7);
    frameEvent(32'd3, 32'd5, 1'b0, '0, 1'b0, d);
    checkStats("R11 wrapped duration R6");
    runSchedule(d, "R11 wrapped elapsed R3");
    checkAvg("R11");

    // R2 time base
    check(nowUs == nowModel, "R2 after ticks", nowUs, nowModel);
    repeat (5) @(negedge clk);
    check(nowUs == nowModel, "R2 hold without tick", nowUs, nowModel);

    // sweep minimum and elapsed (R3, R4, R6, R7, R9)
    for (int m = 0; m <= 6; m++) begin
      setMin(32'(m));
      for (int e = 0; e <= 6; e++) begin
        frameEvent(32'(e), 32'((e * 5 + m * 3) % 17 + 2), 1'b0, '0, 1'b0, d);
        checkStats("R6 R7 sweep");
        if (e < m) runSchedule(d, "R3 sweep");
        else runSchedule(d, "R4 sweep");
        checkAvg("R9 sweep");
      end
    end

    // R5: same-cycle write uses the old minimum
    setMin(32'd0);
    frameEvent(32'd0, 32'd4, 1'b1, 32'd5, 1'b0, d);
    check(d == 32'd1, "R5 old minimum model", d, 1);
    runSchedule(32'd1, "R5 same-cycle write ignored");
    frameEvent(32'd0, 32'd4, 1'b0, '0, 1'b0, d);
    runSchedule(32'd5, "R5 new minimum applied");

    // R10: restart while pending
    setMin(32'd10);
    frameEvent(32'd0, 32'd9, 1'b0, '0, 1'b0, d);
    for (int k = 0; k < 4; k++) begin
      tickOnce();
      check(frameReq == 1'b0, "R10 no early request", frameReq, 0);
    end
    frameEvent(32'd8, 32'd40, 1'b0, '0, 1'b0, d);
    runSchedule(32'd2, "R10 restarted wait");
    checkAvg("R10");

    // R8: clear with frame-done in the same cycle
    frameEvent(32'd20, 32'd30, 1'b0, '0, 1'b1, d);
    checkStats("R8 cleared");
    check(avgValid == 1'b0, "R8 avgValid cleared", avgValid, 0);
    runSchedule(d, "R8 request still scheduled R4");
    frameEvent(32'd20, 32'd12, 1'b0, '0, 1'b0, d);
    checkStats("R8 after clear");
    runSchedule(d, "R8 R4 after clear");
    checkAvg("R8");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule